// File: doc/BRIEF.md
# Random-Length Packet Traffic Generator

This block is a traffic source for exercising a packet link. It emits an endless series of framed packets on a word stream with a valid/ready handshake. The first word of each packet is flagged as the start and the last word as the end. Packet lengths vary pseudo-randomly but always stay inside a fixed legal window. The payload is a running word counter, so a receiver can prove that no word was lost, repeated or reordered.

The length of each packet comes from a 31-bit linear feedback shift register. The register steps once per packet, and its value is reduced modulo the width of the window and offset by the minimum length. The payload counter is never cleared between packets. A count of completed packets is offered as an output. The source honours backpressure: while the sink withholds ready, the word on offer does not change.

Top module: `rand_pkt_gen`

## Requirements
- R1: While reset is asserted, valid, first and last are low and the packet count is zero. The first word offered after reset carries payload value 0 and has first set.
- R2: Every packet holds between 8 and 504 words, inclusive.
- R3: The length of a packet is 8 + (S mod 497). S is the 31-bit shift-register state in force for that packet. It equals the seed for the first packet after reset, and it steps once for each packet that follows. On a step, every bit moves up one place and bit 0 takes the XOR of bits 30 and 27 (polynomial x^31 + x^28 + 1).
- R4: first is high on exactly the first word of a packet, and last is high on exactly its final word. The word after a last word starts a new packet.
- R5: Each accepted word (valid and ready high at a clock edge) carries payload one greater, modulo 2^32, than the word accepted before it. This holds across packet boundaries.
- R6: While valid is high and ready is low, the next cycle keeps valid high and keeps data, first and last unchanged.
- R7: The packet count rises by one in the cycle after a last word is accepted, and it does not change otherwise.
- R8: valid rises on the first clock edge after reset is released and stays high from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_ready | input | 1 | Sink can take the word on offer |
| tx_data | output | 32 | Payload word (running counter) |
| tx_valid | output | 1 | A word is on offer |
| tx_first | output | 1 | Word on offer is the first of its packet |
| tx_last | output | 1 | Word on offer is the last of its packet |
| pkt_count | output | 32 | Number of packets fully accepted since reset |

## Verification
A wrong shift-register state or a wrong length reduction does not show until the end of the packet. There, last arrives on the wrong word, so the reference model catches it within one packet, at most 504 accepted words after the fault. A wrong word index shows at the next word as a misplaced first or last flag. A counter fault shows in the payload of the very next accepted word. Mishandling of stalls shows in the cycle after ready drops, because the offered word changes. The bench checks every cycle against a model that carries its own shift-register arithmetic. Ready patterns include full rate, pseudo-random gaps, long stalls, alternate-cycle acceptance, and a reset in mid-packet.

// File: rtl/rand_pkt_gen.sv
module rand_pkt_gen #(
  parameter int WORD_W  = 32,
  parameter int LFSR_W  = 31,
  parameter int TAP_A   = 31,
  parameter int TAP_B   = 28,
  parameter int MIN_LEN = 8,
  parameter int MAX_LEN = 504,
  parameter int CNT_W   = 32,
  parameter logic [LFSR_W-1:0] SEED = 'h2A5A1234
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              tx_first,
  output logic              tx_last,
  output logic [CNT_W-1:0]  pkt_count
);
  localparam int SPAN  = MAX_LEN - MIN_LEN + 1;
  localparam int LEN_W = $clog2(MAX_LEN + 1);

  function automatic logic [LEN_W-1:0] fold(input logic [LFSR_W-1:0] v);
    logic [LEN_W:0] r;
    r = '0;
    for (int i = LFSR_W - 1; i >= 0; i--) begin
      r = {r[LEN_W-1:0], v[i]};
      if (r >= (LEN_W+1)'(SPAN)) r = r - (LEN_W+1)'(SPAN);
    end
    return r[LEN_W-1:0];
  endfunction

  logic [LFSR_W-1:0] lfsr;
  logic [LEN_W-1:0]  idx;
  logic [LEN_W-1:0]  cur_len;
  logic [WORD_W-1:0] word;
  logic              valid_q;
  logic              fire, at_end;

  assign cur_len  = LEN_W'(MIN_LEN) + fold(lfsr);
  assign at_end   = (idx == cur_len - LEN_W'(1));
  assign fire     = valid_q & tx_ready;

  assign tx_valid = valid_q;
  assign tx_data  = word;
  assign tx_first = valid_q & (idx == '0);
  assign tx_last  = valid_q & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      lfsr      <= SEED;
      idx       <= '0;
      word      <= '0;
      pkt_count <= '0;
    end else begin
      valid_q <= 1'b1;
      if (fire) begin
        word <= word + WORD_W'(1);
        if (at_end) begin
          idx       <= '0;
          lfsr      <= {lfsr[LFSR_W-2:0], lfsr[TAP_A-1] ^ lfsr[TAP_B-1]};
          pkt_count <= pkt_count + CNT_W'(1);
        end else begin
          idx <= idx + LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rand_pkt_gen_chk.sv
module rand_pkt_gen_chk #(
  parameter int WORD_W  = 32,
  parameter int MIN_LEN = 8,
  parameter int MAX_LEN = 504,
  parameter int CNT_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              valid,
  input logic [WORD_W-1:0] data,
  input logic              sop,
  input logic              eop,
  input logic [CNT_W-1:0]  pkt_count
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  logic [LEN_W-1:0] wc;
  logic             acc;
  assign acc = valid & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   wc <= '0;
    else if (acc) wc <= eop ? '0 : wc + LEN_W'(1);
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !valid && !sop && !eop && pkt_count == '0);
  p_len_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && eop |-> int'(wc) + 1 >= MIN_LEN);
  p_len_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> int'(wc) < MAX_LEN);
  p_sop_place_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> sop == (wc == '0));
  p_data_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> data == $past(data) + WORD_W'(1));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(data) && $stable(sop) && $stable(eop));
  p_count_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && eop |=> pkt_count == $past(pkt_count) + CNT_W'(1));
  p_count_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && eop) |=> $stable(pkt_count));
  p_valid_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);
endmodule

bind rand_pkt_gen rand_pkt_gen_chk #(
  .WORD_W(WORD_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(tx_ready), .valid(tx_valid), .data(tx_data),
  .sop(tx_first), .eop(tx_last), .pkt_count(pkt_count)
);

// File: tb/tb_rand_pkt_gen.sv
`timescale 1ns/1ps
module tb_rand_pkt_gen;
  localparam logic [30:0] TB_SEED = 31'h2A5A1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic        tx_valid, tx_first, tx_last;
  logic [31:0] pkt_count;

  rand_pkt_gen #(.SEED(TB_SEED)) dut (
    .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_first(tx_first), .tx_last(tx_last), .pkt_count(pkt_count)
  );

  always #2.5 clk = ~clk;

  int  checks = 0, errors = 0;
  bit  done = 0;

  longint m_s, m_data;
  int     m_idx, m_len, m_cnt, obs_words;
  bit     m_valid, fresh, stalled;

  function automatic longint lfsr_step(longint s);
    longint fb;
    fb = ((s >> 30) ^ (s >> 27)) & 1;
    return ((s << 1) | fb) & 64'h7FFF_FFFF;
  endfunction

  function automatic int len_of(longint s);
    return 8 + int'(s % 497);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      check(!tx_valid && !tx_first && !tx_last && pkt_count == 0, "R1", "reset outputs",
            {tx_valid, tx_first, tx_last}, 0);
      m_s = longint'(TB_SEED); m_len = len_of(m_s); m_idx = 0; m_data = 0;
      m_cnt = 0; m_valid = 0; fresh = 1; stalled = 0; obs_words = 0;
    end else begin
      bit es, ee;
      es = m_valid && m_idx == 0;
      ee = m_valid && m_idx == m_len - 1;
      check(tx_valid == m_valid, "R8", "valid", tx_valid, m_valid);
      if (m_valid)
        check(tx_data == 32'(m_data), stalled ? "R6" : "R5", "data", tx_data, 32'(m_data));
      check(tx_first == es, "R4", "first", tx_first, es);
      check(tx_last == ee, "R4", "last", tx_last, ee);
      check(pkt_count == 32'(m_cnt), "R7", "count", pkt_count, m_cnt);
      if (fresh && m_valid) begin
        check(tx_first && tx_data == 0, "R1", "first word after reset", tx_data, 0);
        fresh = 0;
      end
      if (tx_valid && tx_ready) begin
        if (tx_last) begin
          check(obs_words + 1 >= 8 && obs_words + 1 <= 504, "R2", "length range", obs_words + 1, m_len);
          check(obs_words + 1 == m_len, "R3", "length from shift register", obs_words + 1, m_len);
          obs_words = 0;
        end else obs_words++;
      end
      stalled = m_valid && !tx_ready;
      if (m_valid && tx_ready) begin
        m_data = (m_data + 1) & 64'hFFFF_FFFF;
        if (m_idx == m_len - 1) begin
          m_idx = 0; m_s = lfsr_step(m_s); m_len = len_of(m_s); m_cnt++;
        end else m_idx++;
      end
      m_valid = 1;
    end
  end

  initial begin
    int x = 32'h1357_9BDF;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    tx_ready = 1;
    repeat (3000) @(posedge clk);
    for (int i = 0; i < 6000; i++) begin
      @(posedge clk); #1;
      x = x ^ (x << 13); x = x ^ (x >>> 17); x = x ^ (x << 5);
      tx_ready = x[3] | x[9];
    end
    @(posedge clk); #1 tx_ready = 0;
    repeat (50) @(posedge clk);
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1 tx_ready = i[0];
    end
    @(posedge clk); #1 rst_n = 0; tx_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (1500) @(posedge clk);
    @(negedge clk); #1;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule